// File: doc/BRIEF.md
# In-Order Commit Buffer with Whole-Instruction Retirement

This block sits between the out-of-order execution core and the architectural register file. The front end allocates one micro-op per cycle into a 40-entry circular buffer, in program order. Each allocation carries a destination register, an instruction pointer and a flag that marks the last micro-op of its macro-instruction. The block returns the slot tag it assigned. Execution units later return results through three write-back ports, in any order, addressed by that tag. A write-back can also flag the micro-op as faulting or as a mispredicted branch.

Commit runs from the oldest entry and examines a window of up to three entries per cycle. A macro-instruction commits only when every one of its micro-ops, up to and including the end mark, is complete. Its micro-ops then leave together on the commit lanes, one cycle after the check. A fault flag has no effect until the faulting micro-op is the next thing to commit. At that point the block drops the faulting instruction and everything younger, pulses a clear output, and keeps a record of the tag and instruction pointer for a handler. A mispredicted branch instruction commits first, and then the same clear discards every younger entry. After a clear the buffer is empty and allocation restarts at tag 0.

Top module: `rob_top`

## Requirements
- R1: The buffer holds 40 entries. Allocation hands out consecutive tags, counting from 0 after reset or a clear and wrapping from 39 to 0. `alloc_ready` is low while 40 entries are live.
- R2: A write-back on any of the three ports marks its entry complete and stores the result, in any order. A write-back whose tag names an entry that is not live is ignored. That entry is still incomplete after it is allocated later.
- R3: Entries commit strictly in allocation order, at most three per cycle. The oldest entry of a cycle is placed on lane 0 (`rt_we` bit 0), and lanes fill contiguously from there.
- R4: A macro-instruction has at most three micro-ops. It commits in a single cycle, and only when all of its micro-ops up to its end mark are complete. No subset of it ever commits.
- R5: The final write-back completes an entry at clock edge N. The commit check uses it in the following cycle. The result appears on the commit lanes after edge N+1.
- R6: A fault flag on an entry that is not yet at commit is only recorded. It causes no clear and no commit change.
- R7: When a faulting micro-op reaches commit, its instruction and all younger entries do not commit. Complete instructions older than it in the same window still commit. `clear_out` pulses for one cycle with `clear_kind`=1. `ev_tag` and `ev_ip` hold the faulting micro-op's tag and instruction pointer.
- R8: A mispredicted branch instruction commits, and then `clear_out` pulses with `clear_kind`=0 and `ev_tag` set to the branch's tag. Younger entries never commit, even if they are complete.
- R9: In the cycle `clear_out` is high, the buffer is already empty and `alloc_ready` is low. Afterwards `alloc_tag` is 0.
- R10: After reset, `alloc_ready`=1, `alloc_tag`=0, `rt_we`=0 and `clear_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate one micro-op this cycle |
| alloc_eom | input | 1 | Micro-op is the last of its macro-instruction |
| alloc_dest | input | 5 | Architectural destination register |
| alloc_ip | input | 32 | Instruction pointer of the micro-op |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_tag | output | 6 | Tag given to the micro-op being allocated |
| wb_valid | input | 3 | Write-back strobe per port |
| wb_tag | input | 18 | Tag per port, port p at bits 6p+5:6p |
| wb_data | input | 96 | Result per port, port p at bits 32p+31:32p |
| wb_fault | input | 3 | Micro-op faulted, per port |
| wb_mis | input | 3 | Branch was mispredicted, per port |
| rt_we | output | 3 | Commit lane write enables, lane 0 oldest |
| rt_dest | output | 15 | Destination register per lane |
| rt_data | output | 96 | Result per lane |
| clear_out | output | 1 | One-cycle pipeline clear |
| clear_kind | output | 1 | 0 = branch mispredict, 1 = fault |
| ev_tag | output | 6 | Tag of the micro-op that caused the last clear |
| ev_ip | output | 32 | Instruction pointer of that micro-op |

## Verification
The assertions check every cycle that the occupancy never exceeds capacity and that allocation stalls when the buffer is full. They also check that commit lanes are always a contiguous run from lane 0, that every commit decision reaches the lanes exactly one cycle later, and that a clear leaves the buffer empty with allocation held off. Other behaviours need the bench's scenarios, because they depend on the order of write-backs: that no partial instruction ever commits, that a fault seen early is deferred, that older work commits alongside a fault, that younger complete work is dropped after a mispredict, and that stale write-backs are ignored. The bench sweeps instruction sizes 1 to 3, with each micro-op in turn held back. It also fills the buffer across the wrap and completes it in a scrambled order on all three ports.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic {
    CLR_BRANCH = 1'b0,
    CLR_FAULT  = 1'b1
  } clr_kind_e;

  // Add an offset to a ring index; both operands are below depth.
  function automatic int unsigned ring_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned depth);
    int unsigned s;
    s = a + b;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 40,
  parameter int unsigned NWB    = 3,
  parameter int unsigned RET_W  = 3,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IP_W   = 32,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TAG_W-1:0]        head,
  input  logic [TAG_W-1:0]        tail,
  input  logic                    alloc_we,
  input  logic                    alloc_eom,
  input  logic [REG_W-1:0]        alloc_dest,
  input  logic [IP_W-1:0]         alloc_ip,
  input  logic [NWB-1:0]          wb_valid,
  input  logic [NWB*TAG_W-1:0]    wb_tag,
  input  logic [NWB*DATA_W-1:0]   wb_data,
  input  logic [NWB-1:0]          wb_fault,
  input  logic [NWB-1:0]          wb_mis,
  input  logic [CNT_W-1:0]        ret_n,
  input  logic                    clr,
  output logic [RET_W-1:0]        win_valid,
  output logic [RET_W-1:0]        win_done,
  output logic [RET_W-1:0]        win_fault,
  output logic [RET_W-1:0]        win_mis,
  output logic [RET_W-1:0]        win_eom,
  output logic [RET_W*REG_W-1:0]  win_dest,
  output logic [RET_W*DATA_W-1:0] win_data,
  output logic [RET_W*IP_W-1:0]   win_ip
);

  logic [DEPTH-1:0] v_all, dn_all, ft_all, ms_all, eom_all;
  logic [REG_W-1:0]  dest_all [DEPTH];
  logic [DATA_W-1:0] data_all [DEPTH];
  logic [IP_W-1:0]   ip_all   [DEPTH];
  logic [DEPTH-1:0]  ret_mask;

  // Entries leaving through commit this cycle
  always_comb begin
    ret_mask = '0;
    for (int k = 0; k < int'(RET_W); k++) begin
      if (k < int'(ret_n))
        ret_mask[TAG_W'(ring_add(32'(head), k, DEPTH))] = 1'b1;
    end
  end

  for (genvar e = 0; e < int'(DEPTH); e++) begin : g_ent
    logic v_q, v_d, dn_q, dn_d, ft_q, ft_d, ms_q, ms_d;
    logic eom_q;
    logic [REG_W-1:0]  dest_q;
    logic [IP_W-1:0]   ip_q;
    logic [DATA_W-1:0] data_q, data_d;
    logic alloc_hit, wb_any;

    always_comb begin
      alloc_hit = alloc_we && (tail == TAG_W'(e));
      wb_any    = 1'b0;
      dn_d      = dn_q;
      ft_d      = ft_q;
      ms_d      = ms_q;
      data_d    = data_q;
      for (int p = 0; p < int'(NWB); p++) begin
        if (wb_valid[p] && v_q && (wb_tag[p*TAG_W +: TAG_W] == TAG_W'(e))) begin
          wb_any = 1'b1;
          dn_d   = 1'b1;
          ft_d   = wb_fault[p];
          ms_d   = wb_mis[p];
          data_d = wb_data[p*DATA_W +: DATA_W];
        end
      end
      if (alloc_hit) begin
        dn_d = 1'b0;
        ft_d = 1'b0;
        ms_d = 1'b0;
      end
      v_d = v_q;
      if (ret_mask[e]) v_d = 1'b0;
      if (alloc_hit)   v_d = 1'b1;
      if (clr)         v_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q  <= 1'b0;
        dn_q <= 1'b0;
        ft_q <= 1'b0;
        ms_q <= 1'b0;
      end else begin
        v_q  <= v_d;
        dn_q <= dn_d;
        ft_q <= ft_d;
        ms_q <= ms_d;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_hit) begin
        eom_q  <= alloc_eom;
        dest_q <= alloc_dest;
        ip_q   <= alloc_ip;
      end
    end

    always_ff @(posedge clk) begin
      if (wb_any) data_q <= data_d;
    end

    assign v_all[e]    = v_q;
    assign dn_all[e]   = dn_q;
    assign ft_all[e]   = ft_q;
    assign ms_all[e]   = ms_q;
    assign eom_all[e]  = eom_q;
    assign dest_all[e] = dest_q;
    assign data_all[e] = data_q;
    assign ip_all[e]   = ip_q;
  end

  // Commit window: RET_W entries starting at the head
  always_comb begin
    for (int k = 0; k < int'(RET_W); k++) begin
      logic [TAG_W-1:0] idx;
      idx = TAG_W'(ring_add(32'(head), k, DEPTH));
      win_valid[k] = v_all[idx];
      win_done[k]  = dn_all[idx];
      win_fault[k] = ft_all[idx];
      win_mis[k]   = ms_all[idx];
      win_eom[k]   = eom_all[idx];
      win_dest[k*REG_W +: REG_W]   = dest_all[idx];
      win_data[k*DATA_W +: DATA_W] = data_all[idx];
      win_ip[k*IP_W +: IP_W]       = ip_all[idx];
    end
  end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
  parameter int unsigned RET_W = 3,
  parameter int unsigned CNT_W = 2
) (
  input  logic [RET_W-1:0] win_valid,
  input  logic [RET_W-1:0] win_done,
  input  logic [RET_W-1:0] win_fault,
  input  logic [RET_W-1:0] win_mis,
  input  logic [RET_W-1:0] win_eom,
  output logic [CNT_W-1:0] ret_n,
  output logic             fault_fire,
  output logic             mis_fire,
  output logic [CNT_W-1:0] ev_pos
);

  // Scan oldest first; only whole groups closed by an end mark count.
  always_comb begin
    logic blocked, grp_mis;
    ret_n      = '0;
    fault_fire = 1'b0;
    mis_fire   = 1'b0;
    ev_pos     = '0;
    blocked    = 1'b0;
    grp_mis    = 1'b0;
    for (int k = 0; k < int'(RET_W); k++) begin
      if (!blocked) begin
        if (!(win_valid[k] && win_done[k])) begin
          blocked = 1'b1;
        end else if (win_fault[k]) begin
          fault_fire = 1'b1;
          ev_pos     = CNT_W'(k);
          blocked    = 1'b1;
        end else begin
          grp_mis = grp_mis | win_mis[k];
          if (win_eom[k]) begin
            ret_n = CNT_W'(k + 1);
            if (grp_mis) begin
              mis_fire = 1'b1;
              ev_pos   = CNT_W'(k);
              blocked  = 1'b1;
            end
            grp_mis = 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 40,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned CNT_W  = 2,
  parameter int unsigned OCC_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [CNT_W-1:0] ret_n,
  input  logic             clr_fire,
  input  logic             clear_busy,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [OCC_W-1:0] count,
  output logic             alloc_ready,
  output logic             alloc_we
);

  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [OCC_W-1:0] count_q, count_d;

  assign alloc_ready = (count_q < OCC_W'(DEPTH)) && !clr_fire && !clear_busy;
  assign alloc_we    = alloc_valid && alloc_ready;

  always_comb begin
    if (clr_fire) begin
      head_d  = '0;
      tail_d  = '0;
      count_d = '0;
    end else begin
      head_d  = TAG_W'(ring_add(32'(head_q), 32'(ret_n), DEPTH));
      tail_d  = alloc_we ? TAG_W'(ring_add(32'(tail_q), 1, DEPTH)) : tail_q;
      count_d = count_q + OCC_W'(alloc_we) - OCC_W'(ret_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = count_q;

endmodule

// File: rtl/rob_commit.sv
module rob_commit
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 40,
  parameter int unsigned RET_W  = 3,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IP_W   = 32,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TAG_W-1:0]        head,
  input  logic [CNT_W-1:0]        ret_n,
  input  logic                    fault_fire,
  input  logic                    mis_fire,
  input  logic [CNT_W-1:0]        ev_pos,
  input  logic [RET_W*REG_W-1:0]  win_dest,
  input  logic [RET_W*DATA_W-1:0] win_data,
  input  logic [RET_W*IP_W-1:0]   win_ip,
  output logic [RET_W-1:0]        rt_we,
  output logic [RET_W*REG_W-1:0]  rt_dest,
  output logic [RET_W*DATA_W-1:0] rt_data,
  output logic                    clear_out,
  output clr_kind_e               clear_kind,
  output logic [TAG_W-1:0]        ev_tag,
  output logic [IP_W-1:0]         ev_ip
);

  logic [RET_W-1:0] we_q, we_d;
  logic [RET_W*REG_W-1:0]  dest_q;
  logic [RET_W*DATA_W-1:0] data_q;
  logic clr_q, clr_d, cap_en, ev_en;
  clr_kind_e kind_q, kind_d;
  logic [TAG_W-1:0] evt_q, evt_d;
  logic [IP_W-1:0]  evip_q, evip_d;

  always_comb begin
    for (int k = 0; k < int'(RET_W); k++) we_d[k] = (k < int'(ret_n));
    cap_en = (ret_n != '0);
    clr_d  = fault_fire || mis_fire;
    ev_en  = clr_d;
    kind_d = fault_fire ? CLR_FAULT : CLR_BRANCH;
    evt_d  = TAG_W'(ring_add(32'(head), 32'(ev_pos), DEPTH));
    evip_d = win_ip[int'(ev_pos)*IP_W +: IP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= '0;
      clr_q  <= 1'b0;
      kind_q <= CLR_BRANCH;
      evt_q  <= '0;
      evip_q <= '0;
    end else begin
      we_q  <= we_d;
      clr_q <= clr_d;
      if (ev_en) begin
        kind_q <= kind_d;
        evt_q  <= evt_d;
        evip_q <= evip_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      dest_q <= win_dest;
      data_q <= win_data;
    end
  end

  assign rt_we      = we_q;
  assign rt_dest    = dest_q;
  assign rt_data    = data_q;
  assign clear_out  = clr_q;
  assign clear_kind = kind_q;
  assign ev_tag     = evt_q;
  assign ev_ip      = evip_q;

endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 40,
  parameter int unsigned NWB    = 3,
  parameter int unsigned RET_W  = 3,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IP_W   = 32,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  input  logic                    alloc_eom,
  input  logic [REG_W-1:0]        alloc_dest,
  input  logic [IP_W-1:0]         alloc_ip,
  output logic                    alloc_ready,
  output logic [TAG_W-1:0]        alloc_tag,
  input  logic [NWB-1:0]          wb_valid,
  input  logic [NWB*TAG_W-1:0]    wb_tag,
  input  logic [NWB*DATA_W-1:0]   wb_data,
  input  logic [NWB-1:0]          wb_fault,
  input  logic [NWB-1:0]          wb_mis,
  output logic [RET_W-1:0]        rt_we,
  output logic [RET_W*REG_W-1:0]  rt_dest,
  output logic [RET_W*DATA_W-1:0] rt_data,
  output logic                    clear_out,
  output logic                    clear_kind,
  output logic [TAG_W-1:0]        ev_tag,
  output logic [IP_W-1:0]         ev_ip
);

  localparam int unsigned CNT_W = $clog2(RET_W + 1);
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] head, tail;
  logic [OCC_W-1:0] count_q;
  logic             alloc_we, fault_fire, mis_fire, clr_fire;
  logic [CNT_W-1:0] ret_n, ev_pos;
  logic [RET_W-1:0] win_valid, win_done, win_fault, win_mis, win_eom;
  logic [RET_W*REG_W-1:0]  win_dest;
  logic [RET_W*DATA_W-1:0] win_data;
  logic [RET_W*IP_W-1:0]   win_ip;
  clr_kind_e kind;

  assign clr_fire   = fault_fire || mis_fire;
  assign alloc_tag  = tail;
  assign clear_kind = kind;

  rob_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .ret_n(ret_n),
    .clr_fire(clr_fire), .clear_busy(clear_out), .head(head), .tail(tail),
    .count(count_q), .alloc_ready(alloc_ready), .alloc_we(alloc_we)
  );

  rob_store #(.DEPTH(DEPTH), .NWB(NWB), .RET_W(RET_W), .REG_W(REG_W),
              .DATA_W(DATA_W), .IP_W(IP_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .head(head), .tail(tail), .alloc_we(alloc_we),
    .alloc_eom(alloc_eom), .alloc_dest(alloc_dest), .alloc_ip(alloc_ip),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .wb_fault(wb_fault), .wb_mis(wb_mis), .ret_n(ret_n), .clr(clr_fire),
    .win_valid(win_valid), .win_done(win_done), .win_fault(win_fault),
    .win_mis(win_mis), .win_eom(win_eom), .win_dest(win_dest),
    .win_data(win_data), .win_ip(win_ip)
  );

  rob_retire_sel #(.RET_W(RET_W), .CNT_W(CNT_W)) u_sel (
    .win_valid(win_valid), .win_done(win_done), .win_fault(win_fault),
    .win_mis(win_mis), .win_eom(win_eom), .ret_n(ret_n),
    .fault_fire(fault_fire), .mis_fire(mis_fire), .ev_pos(ev_pos)
  );

  rob_commit #(.DEPTH(DEPTH), .RET_W(RET_W), .REG_W(REG_W), .DATA_W(DATA_W),
               .IP_W(IP_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .head(head), .ret_n(ret_n),
    .fault_fire(fault_fire), .mis_fire(mis_fire), .ev_pos(ev_pos),
    .win_dest(win_dest), .win_data(win_data), .win_ip(win_ip),
    .rt_we(rt_we), .rt_dest(rt_dest), .rt_data(rt_data),
    .clear_out(clear_out), .clear_kind(kind), .ev_tag(ev_tag), .ev_ip(ev_ip)
  );

endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int unsigned DEPTH = 40,
  parameter int unsigned RET_W = 3,
  parameter int unsigned CNT_W = 2,
  parameter int unsigned OCC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OCC_W-1:0] count,
  input logic             alloc_ready,
  input logic [RET_W-1:0] rt_we,
  input logic [CNT_W-1:0] ret_n,
  input logic             clr_fire,
  input logic             clear_out
);

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= OCC_W'(DEPTH));  // R1
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (count == OCC_W'(DEPTH)) |-> !alloc_ready);  // R1
  AST_LANE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_we & (rt_we + RET_W'(1))) == '0);  // R3
  AST_COMMIT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_n != '0) |=> rt_we[0]);  // R5
  AST_CLEAR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> clear_out);  // R7
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear_out |-> (count == '0) && !alloc_ready);  // R9

endmodule

bind rob_top rob_chk #(
  .DEPTH(DEPTH), .RET_W(RET_W),
  .CNT_W($clog2(RET_W + 1)), .OCC_W($clog2(DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count_q), .alloc_ready(alloc_ready),
  .rt_we(rt_we), .ret_n(ret_n), .clr_fire(clr_fire), .clear_out(clear_out)
);

// File: tb/sim_rob_top.sv
`timescale 1ns/1ps
module sim_rob_top;

  localparam int DEPTH = 40;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, alloc_eom;
  logic [4:0] alloc_dest;
  logic [31:0] alloc_ip;
  logic alloc_ready;
  logic [TW-1:0] alloc_tag;
  logic [2:0] wb_valid, wb_fault, wb_mis;
  logic [3*TW-1:0] wb_tag;
  logic [95:0] wb_data;
  logic [2:0] rt_we;
  logic [14:0] rt_dest;
  logic [95:0] rt_data;
  logic clear_out, clear_kind;
  logic [TW-1:0] ev_tag;
  logic [31:0] ev_ip;

  rob_top u0 (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int ret_cnt = 0, clr_cnt = 0, max_batch = 0, last_batch = 0, mon_b;
  int log_data [256];
  int log_dest [256];
  int clr_kind_seen, clr_tag_seen, clr_ip_seen, clr_ready_seen;
  int exp_tail = 0, serial = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Observe registered outputs 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      mon_b = 0;
      for (int k = 0; k < 3; k++) begin
        if (rt_we[k]) begin
          log_data[ret_cnt % 256] = int'(rt_data[k*32 +: 32]);
          log_dest[ret_cnt % 256] = int'(rt_dest[k*5 +: 5]);
          ret_cnt++;
          mon_b++;
        end
      end
      if (mon_b > max_batch) max_batch = mon_b;
      if (mon_b != 0) last_batch = mon_b;
      if (clear_out) begin
        clr_cnt++;
        clr_kind_seen  = int'(clear_kind);
        clr_tag_seen   = int'(ev_tag);
        clr_ip_seen    = int'(ev_ip);
        clr_ready_seen = int'(alloc_ready);
      end
    end
  end

  task automatic do_alloc(input bit eom, input int ip, output int tag, output int d);
    chk(alloc_ready == 1'b1, "R1 ready before alloc", int'(alloc_ready), 1);
    alloc_valid = 1'b1;
    alloc_eom   = eom;
    alloc_dest  = 5'(serial);
    alloc_ip    = 32'(ip);
    tag = int'(alloc_tag);
    d   = 32'h0000_A000 + serial;
    chk(tag == exp_tail, "R1 tag order", tag, exp_tail);
    exp_tail = (exp_tail + 1) % DEPTH;
    serial++;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic set_wb(input int p, input int tag, input int d, input bit f, input bit m);
    wb_valid[p] = 1'b1;
    wb_tag[p*TW +: TW] = TW'(tag);
    wb_data[p*32 +: 32] = 32'(d);
    wb_fault[p] = f;
    wb_mis[p] = m;
  endtask

  task automatic do_wb(input int p, input int tag, input int d, input bit f, input bit m);
    set_wb(p, tag, d, f, m);
    @(negedge clk);
    wb_valid = '0;
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int tg [40];
    int dv [40];
    int base, c0, t_a, t_b, d_a, d_b, t_x, d_x, dummy;
    rst_n = 1'b0;
    alloc_valid = 0; alloc_eom = 0; alloc_dest = '0; alloc_ip = '0;
    wb_valid = '0; wb_tag = '0; wb_data = '0; wb_fault = '0; wb_mis = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(alloc_ready == 1'b1, "R10 alloc_ready", int'(alloc_ready), 1);
    chk(alloc_tag == '0, "R10 alloc_tag", int'(alloc_tag), 0);
    chk(rt_we == '0, "R10 rt_we", int'(rt_we), 0);
    chk(clear_out == 1'b0, "R10 clear_out", int'(clear_out), 0);

    // Sweep group size and held-back micro-op (R4, R5, R3)
    for (int g = 1; g <= 3; g++) begin
      for (int h = 0; h < g; h++) begin
        base = ret_cnt;
        for (int j = 0; j < g; j++) do_alloc(j == g - 1, 32'h100 + j, tg[j], dv[j]);
        for (int j = 0; j < g; j++)
          if (j != h) do_wb(j % 3, tg[j], dv[j], 0, 0);
        repeat (3) @(negedge clk);
        chk(ret_cnt == base, "R4 partial group held", ret_cnt - base, 0);
        do_wb(2 - (h % 3), tg[h], dv[h], 0, 0);
        chk(ret_cnt == base, "R5 not before two cycles", ret_cnt - base, 0);
        @(negedge clk);
        chk(ret_cnt == base + g, "R5 commit after two cycles", ret_cnt - base, g);
        chk(last_batch == g, "R4 whole group one cycle", last_batch, g);
        for (int j = 0; j < g; j++)
          chk(log_data[(base + j) % 256] == dv[j], "R3 commit order", log_data[(base + j) % 256], dv[j]);
      end
    end

    // Fill across wrap, complete scrambled on three ports (R1, R2, R3)
    base = ret_cnt;
    max_batch = 0;
    for (int j = 0; j < DEPTH; j++) do_alloc(1, 32'h200 + j, tg[j], dv[j]);
    chk(alloc_ready == 1'b0, "R1 full stalls", int'(alloc_ready), 0);
    for (int c = 0; c < DEPTH; c += 3) begin
      for (int p = 0; p < 3; p++) begin
        if (c + p < DEPTH) begin
          int j;
          j = ((c + p) * 7) % DEPTH;
          set_wb(p, tg[j], dv[j], 0, 0);
        end
      end
      @(negedge clk);
      wb_valid = '0;
    end
    repeat (20) @(negedge clk);
    chk(ret_cnt == base + DEPTH, "R2 all completed commit", ret_cnt - base, DEPTH);
    chk(max_batch == 3, "R3 three per cycle", max_batch, 3);
    for (int j = 0; j < DEPTH; j++)
      chk(log_data[(base + j) % 256] == dv[j], "R3 in order after scramble", log_data[(base + j) % 256], dv[j]);

    // Stale write-back is ignored (R2)
    base = ret_cnt;
    do_wb(0, exp_tail, 32'h5555, 0, 0);
    do_alloc(1, 32'h300, t_a, d_a);
    repeat (4) @(negedge clk);
    chk(ret_cnt == base, "R2 stale write-back ignored", ret_cnt - base, 0);
    do_wb(1, t_a, d_a, 0, 0);
    @(negedge clk);
    chk(ret_cnt == base + 1 && log_data[base % 256] == d_a, "R2 real write-back", log_data[base % 256], d_a);

    // Fault deferred, then taken at commit with older group retiring (R6, R7, R9)
    base = ret_cnt; c0 = clr_cnt;
    do_alloc(1, 32'h2000, t_a, d_a);
    do_alloc(1, 32'h2004, t_b, d_b);
    do_wb(0, t_b, d_b, 1, 0);
    repeat (4) @(negedge clk);
    chk(clr_cnt == c0, "R6 early fault not acted on", clr_cnt - c0, 0);
    chk(ret_cnt == base, "R6 no commit", ret_cnt - base, 0);
    do_wb(1, t_a, d_a, 0, 0);
    @(negedge clk);
    chk(ret_cnt == base + 1, "R7 older group commits", ret_cnt - base, 1);
    chk(clr_cnt == c0 + 1, "R7 clear pulse", clr_cnt - c0, 1);
    chk(clr_kind_seen == 1, "R7 clear kind fault", clr_kind_seen, 1);
    chk(clr_tag_seen == t_b, "R7 event tag", clr_tag_seen, t_b);
    chk(clr_ip_seen == 32'h2004, "R7 event ip", clr_ip_seen, 32'h2004);
    chk(clr_ready_seen == 0, "R9 alloc blocked during clear", clr_ready_seen, 0);
    @(negedge clk);
    chk(clr_cnt == c0 + 1, "R7 single-cycle clear", clr_cnt - c0, 1);
    chk(alloc_tag == '0, "R9 tag restarts", int'(alloc_tag), 0);
    exp_tail = 0;

    // Fault inside a group: nothing of it commits (R7, R4)
    base = ret_cnt; c0 = clr_cnt;
    do_alloc(0, 32'h3000, t_a, d_a);
    do_alloc(1, 32'h3004, t_b, d_b);
    do_wb(0, t_a, d_a, 0, 0);
    do_wb(2, t_b, d_b, 1, 0);
    @(negedge clk);
    chk(clr_cnt == c0 + 1 && clr_kind_seen == 1, "R7 mid-group fault clears", clr_cnt - c0, 1);
    chk(ret_cnt == base, "R4 faulting group none commit", ret_cnt - base, 0);
    chk(clr_tag_seen == t_b, "R7 mid-group event tag", clr_tag_seen, t_b);
    @(negedge clk);
    exp_tail = 0;

    // Mispredicted branch commits, younger discarded (R8)
    base = ret_cnt; c0 = clr_cnt;
    do_alloc(1, 32'h4000, t_x, d_x);
    do_alloc(1, 32'h4004, t_a, d_a);
    do_alloc(1, 32'h4008, t_b, d_b);
    do_wb(0, t_a, d_a, 0, 0);
    do_wb(1, t_b, d_b, 0, 0);
    do_wb(2, t_x, d_x, 0, 1);
    @(negedge clk);
    chk(ret_cnt == base + 1 && log_data[base % 256] == d_x, "R8 branch commits", ret_cnt - base, 1);
    chk(clr_cnt == c0 + 1 && clr_kind_seen == 0, "R8 clear kind branch", clr_kind_seen, 0);
    chk(clr_tag_seen == t_x, "R8 event tag", clr_tag_seen, t_x);
    repeat (4) @(negedge clk);
    chk(ret_cnt == base + 1, "R8 younger discarded", ret_cnt - base, 1);
    chk(alloc_tag == '0 && alloc_ready, "R9 empty after branch clear", int'(alloc_tag), 0);
    exp_tail = 0;
    do_alloc(1, 32'h5000, dummy, d_a);

    finished = 1;
    report();
  end

endmodule